// File: doc/BRIEF.md
# Counter-Driven Self-Test Sequencer for Chained Cell Rows

This block runs a built-in self-test over a set of identical rows. Each row is a chain of cells, and every cell is set up as a one-to-one mapping of a k-bit word. A k-bit binary counter produces every k-bit value exactly once per test configuration. The same stream feeds the first cell of every row. The sequencer walks through all k+2 configurations. For each one it asks an external loader to install the configuration, waits for the acknowledge, and then drives the counter from 0 up to 2^k-1.

The analyser needs no stored golden responses. It uses only two facts. First, fault-free rows all produce the same output stream. Second, any complete permutation of the k-bit values sums to the same number. In comparison mode, the end-of-row word of every row is compared with row 0 on each cycle of the observation window. In checksum mode, each row's words are added into a 2k-bit accumulator, and the total is tested against 2^k(2^k-1)/2 when the window closes. When the cells register their outputs, the window is delayed by the chain length.

A failure sets a flag and records the configuration index. Both are held until reset. A one-cycle done pulse marks the end of a run.

The control machine has five states:
- IDLE goes to REQ on `start`.
- REQ raises `cfg_req` and goes to APPLY on `cfg_ack`.
- APPLY runs the counter and the window, and goes to CHECK on its last cycle.
- CHECK evaluates the checksums. It then returns to REQ with the next index, or goes to DONE after the last configuration.
- DONE pulses `done` and returns to IDLE.

Top module: `cellarray_bist`

## Requirements
- R1: After reset, `cfg_req`, `pat_en`, `busy`, `done` and `fail` are 0 and `pattern` is 0.
- R2: A `start` pulse in IDLE requests configurations 0 to k+1 in ascending order on `cfg_idx`, one handshake each, k+2 in total. `cfg_req` stays high until `cfg_ack` is seen. A `start` while busy has no effect on the sequence.
- R3: After each acknowledge, `pattern` takes the values 0, 1, …, 2^k-1 on consecutive cycles with `pat_en` high. Exactly 2^k such cycles occur per configuration. `pattern` is the single word fed to all rows.
- R4: Comparison mode (`mode_sel`=0): any window cycle where some row word differs from row 0 sets `fail`. Faults that are identical in every row leave `fail` at 0.
- R5: Checksum mode (`mode_sel`=1): the sum of each row's window words, in 2k bits, must equal 2^k(2^k-1)/2. If it does not, `fail` is set in CHECK. This catches a fault that is identical in all rows.
- R6: With `reg_path`=1, the window opens `CHAIN` cycles after the first pattern and lasts 2^k cycles. Row words before it are ignored. With `reg_path`=0 the window coincides with `pat_en`. Both `mode_sel` and `reg_path` are sampled at start.
- R7: `fail` and `fail_cfg` hold the first failing configuration index until reset, including across later runs.
- R8: `done` is high for one cycle after the last configuration's CHECK. `busy` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted in IDLE only) |
| mode_sel | input | 1 | 0 = cross-row compare, 1 = per-row checksum |
| reg_path | input | 1 | 1 = cells register outputs (window delayed by CHAIN) |
| cfg_req | output | 1 | Request to load configuration `cfg_idx` |
| cfg_idx | output | CFG_W | Configuration being requested or tested |
| cfg_ack | input | 1 | Configuration installed |
| pattern | output | PAT_W | Counter word broadcast to every row |
| pat_en | output | 1 | `pattern` carries a test value |
| row_out | input | ROWS*PAT_W | End-of-row words, row r at bits r*PAT_W upward |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky failure flag |
| fail_cfg | output | CFG_W | First failing configuration index |

## Verification
`cfg_req` is due one cycle after `start`. The first pattern follows one cycle after the acknowledge is sampled. A compare mismatch sets `fail` at the edge that closes the offending window cycle. A checksum fault shows in `fail` one cycle after CHECK, and `done` follows the last CHECK by one cycle. The bench drives inputs on falling edges and samples on falling edges, so every registered result is read one half-period after the edge that produced it. Mismatches are injected only in pre-window cycles to show they are ignored. For comparison-mode faults, the configuration index on the first falling edge that shows `fail` must match the injected configuration.

// File: rtl/cab_pkg.sv
package cab_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_APPLY = 3'd2,
        ST_CHECK = 3'd3,
        ST_DONE  = 3'd4
    } cab_state_e;

    typedef enum logic {
        MODE_CMP = 1'b0,
        MODE_SUM = 1'b1
    } cab_mode_e;
endpackage

// File: rtl/cab_pattern_gen.sv
module cab_pattern_gen #(
    parameter int PAT_W = 3,
    parameter int CHAIN = 4,
    parameter int PH_W  = $clog2(CHAIN + (1 << PAT_W) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             lat_on,
    output logic [PAT_W-1:0] pattern,
    output logic             pat_en,
    output logic             win,
    output logic             last
);
    localparam int NPAT = 1 << PAT_W;
    localparam logic [PH_W-1:0] NPAT_PH = PH_W'(NPAT);
    localparam logic [PH_W-1:0] LAT_PH  = PH_W'(CHAIN);

    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ph <= '0;
        else if (clear) ph <= '0;
        else if (run)   ph <= ph + 1'b1;
    end

    assign lat     = lat_on ? LAT_PH : '0;
    assign pat_en  = run && (ph < NPAT_PH);
    assign pattern = pat_en ? ph[PAT_W-1:0] : '0;
    assign win     = run && (ph >= lat);
    assign last    = run && (ph == lat + NPAT_PH - 1'b1);

    // R3: the counter steps by one while patterns are applied
    a_r3_pattern_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_en && pattern != '1) |=> (pat_en && pattern == $past(pattern) + 1'b1));
endmodule

// File: rtl/cab_row_compare.sv
module cab_row_compare #(
    parameter int PAT_W = 3,
    parameter int ROWS  = 4
) (
    input  logic [ROWS*PAT_W-1:0] rows,
    output logic                  differ
);
    logic [ROWS-1:0] ne;

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_cmp
            assign ne[r] = rows[r*PAT_W +: PAT_W] != rows[PAT_W-1:0];
        end
    endgenerate

    assign differ = |ne;
endmodule

// File: rtl/cab_row_checksum.sv
module cab_row_checksum #(
    parameter int PAT_W = 3,
    parameter int ROWS  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  acc_en,
    input  logic [ROWS*PAT_W-1:0] rows,
    output logic                  sum_bad
);
    localparam int SUM_W = 2 * PAT_W;
    localparam longint NPAT = longint'(1) << PAT_W;
    localparam logic [SUM_W-1:0] EXP_SUM = SUM_W'((NPAT * (NPAT - 1)) / 2);

    logic [ROWS-1:0] bad;

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_acc
            logic [SUM_W-1:0] acc;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      acc <= '0;
                else if (clear)  acc <= '0;
                else if (acc_en) acc <= acc + {{(SUM_W-PAT_W){1'b0}}, rows[r*PAT_W +: PAT_W]};
            end
            assign bad[r] = acc != EXP_SUM;
        end
    endgenerate

    assign sum_bad = |bad;
endmodule

// File: rtl/cellarray_bist.sv
module cellarray_bist
    import cab_pkg::*;
#(
    parameter int PAT_W = 3,
    parameter int ROWS  = 4,
    parameter int CHAIN = 4,
    parameter int CFG_W = $clog2(PAT_W + 2)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  mode_sel,
    input  logic                  reg_path,
    output logic                  cfg_req,
    output logic [CFG_W-1:0]      cfg_idx,
    input  logic                  cfg_ack,
    output logic [PAT_W-1:0]      pattern,
    output logic                  pat_en,
    input  logic [ROWS*PAT_W-1:0] row_out,
    output logic                  busy,
    output logic                  done,
    output logic                  fail,
    output logic [CFG_W-1:0]      fail_cfg
);
    localparam int NUM_CFG = PAT_W + 2;
    localparam logic [CFG_W-1:0] LAST_CFG = CFG_W'(NUM_CFG - 1);

    cab_state_e state, state_nx;
    cab_mode_e  mode_q;
    logic       regp_q;
    logic [CFG_W-1:0] idx_q;
    logic       run, clear, in_check;
    logic       win, last, differ, sum_bad;
    logic       cmp_hit, sum_hit;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)   state_nx = ST_REQ;
            ST_REQ:   if (cfg_ack) state_nx = ST_APPLY;
            ST_APPLY: if (last)    state_nx = ST_CHECK;
            ST_CHECK: state_nx = (idx_q == LAST_CFG) ? ST_DONE : ST_REQ;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register and run context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx_q  <= '0;
            mode_q <= MODE_CMP;
            regp_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                idx_q  <= '0;
                mode_q <= cab_mode_e'(mode_sel);
                regp_q <= reg_path;
            end else if (state == ST_CHECK && idx_q != LAST_CFG) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        cfg_req  = 1'b0;
        run      = 1'b0;
        clear    = 1'b0;
        in_check = 1'b0;
        done     = 1'b0;
        busy     = 1'b1;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_REQ:   begin cfg_req = 1'b1; clear = cfg_ack; end
            ST_APPLY: run = 1'b1;
            ST_CHECK: in_check = 1'b1;
            ST_DONE:  done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    assign cfg_idx = idx_q;

    cab_pattern_gen #(.PAT_W(PAT_W), .CHAIN(CHAIN)) u_gen (
        .clk(clk), .rst_n(rst_n), .clear(clear), .run(run), .lat_on(regp_q),
        .pattern(pattern), .pat_en(pat_en), .win(win), .last(last)
    );

    cab_row_compare #(.PAT_W(PAT_W), .ROWS(ROWS)) u_cmp (
        .rows(row_out), .differ(differ)
    );

    cab_row_checksum #(.PAT_W(PAT_W), .ROWS(ROWS)) u_sum (
        .clk(clk), .rst_n(rst_n), .clear(clear), .acc_en(win),
        .rows(row_out), .sum_bad(sum_bad)
    );

    assign cmp_hit = win && (mode_q == MODE_CMP) && differ;
    assign sum_hit = in_check && (mode_q == MODE_SUM) && sum_bad;

    // sticky verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail     <= 1'b0;
            fail_cfg <= '0;
        end else if (!fail && (cmp_hit || sum_hit)) begin
            fail     <= 1'b1;
            fail_cfg <= idx_q;
        end
    end

    // R2: request held until acknowledged
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack) |=> cfg_req);

    // R2: index stays inside the configuration set
    a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cfg_idx <= LAST_CFG));

    // R7: verdict and index hold once set
    a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> (fail && $stable(fail_cfg)));

    // R8: done is a single-cycle pulse that ends the run
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R3: patterns only appear while a configuration is loaded
    a_r3_pat_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pat_en) |-> (pattern == '0 && $past(cfg_ack)));
endmodule

// File: tb/cellarray_bist_tb_top.sv
module cellarray_bist_tb_top;
    localparam int K     = 3;
    localparam int ROWS  = 4;
    localparam int CHAIN = 4;
    localparam int CW    = $clog2(K + 2);
    localparam int NPAT  = 1 << K;
    localparam int NCFG  = K + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, mode_sel = 1'b0, reg_path = 1'b0, cfg_ack = 1'b0;
    logic cfg_req, pat_en, busy, done, fail;
    logic [CW-1:0] cfg_idx, fail_cfg;
    logic [K-1:0] pattern;
    logic [ROWS*K-1:0] row_out;

    logic [ROWS-1:0] inj_rows = '0;
    logic [7:0]      inj_cfgs = '0;
    logic            glitch   = 1'b0;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cellarray_bist #(.PAT_W(K), .ROWS(ROWS), .CHAIN(CHAIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
        .reg_path(reg_path), .cfg_req(cfg_req), .cfg_idx(cfg_idx),
        .cfg_ack(cfg_ack), .pattern(pattern), .pat_en(pat_en),
        .row_out(row_out), .busy(busy), .done(done), .fail(fail),
        .fail_cfg(fail_cfg)
    );

    // model of the cell rows: each cell xors a configuration-dependent mask
    function automatic logic [K-1:0] fmap(logic [K-1:0] x, logic [CW-1:0] c);
        return x ^ K'(int'(c) * 3);
    endfunction

    logic [K-1:0] st [ROWS][CHAIN];
    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++)
            for (int s = 0; s < CHAIN; s++)
                st[r][s] <= (s == 0) ? fmap(pattern, cfg_idx) : fmap(st[r][s-1], cfg_idx);
    end

    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            logic [K-1:0] v;
            if (reg_path) v = st[r][CHAIN-1];
            else begin
                v = pattern;
                for (int s = 0; s < CHAIN; s++) v = fmap(v, cfg_idx);
            end
            if (inj_rows[r] && inj_cfgs[cfg_idx]) v[0] = 1'b1;
            if (glitch && r == 1 && pat_en && int'(pattern) < CHAIN) v = ~v;
            row_out[r*K +: K] = v;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; cfg_ack = 1'b0;
        inj_rows = '0; inj_cfgs = '0; glitch = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_bist(input logic md, input logic rp, input bit poke,
                            output int hs, output bit seq_ok, output int fail_at);
        int wait_c = 0, pcnt = 0, cyc = 0;
        bit fin = 0;
        logic prev_fail;
        hs = 0; seq_ok = 1; fail_at = -1;
        mode_sel = md; reg_path = rp; start = 1'b1;
        prev_fail = fail;
        @(negedge clk);
        start = 1'b0;
        while (!fin && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            start = (poke && cyc == 12) ? 1'b1 : 1'b0;
            if (pat_en) begin
                if (int'(pattern) != pcnt) seq_ok = 0;
                pcnt++;
            end
            if (fail && !prev_fail) fail_at = int'(cfg_idx);
            prev_fail = fail;
            if (cfg_ack) cfg_ack = 1'b0;
            else if (cfg_req) begin
                if (wait_c == 2) begin
                    if (int'(cfg_idx) != hs) seq_ok = 0;
                    if (hs > 0 && pcnt != NPAT) seq_ok = 0;
                    hs++; pcnt = 0; wait_c = 0; cfg_ack = 1'b1;
                end else wait_c++;
            end
            if (done) begin
                fin = 1;
                if (pcnt != NPAT) seq_ok = 0;
            end
        end
        start = 1'b0;
        @(negedge clk);
        chk("R8 done width", int'(done), 0);
        chk("R8 busy after done", int'(busy), 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 cfg_req", int'(cfg_req), 0);
        chk("R1 pat_en", int'(pat_en), 0);
        chk("R1 pattern", int'(pattern), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 fail", int'(fail), 0);
    endtask

    task automatic t_clean_cmp_poke();
        int hs, fa; bit ok;
        run_bist(1'b0, 1'b0, 1, hs, ok, fa);
        chk("R2 handshake count", hs, NCFG);
        chk("R3 pattern sequence", int'(ok), 1);
        chk("R4 clean compare", int'(fail), 0);
    endtask

    task automatic t_clean_sum_reg();
        int hs, fa; bit ok;
        glitch = 1'b1;
        run_bist(1'b1, 1'b1, 0, hs, ok, fa);
        glitch = 1'b0;
        chk("R6 reg path sequence", int'(ok), 1);
        chk("R6 pre-window ignored (checksum)", int'(fail), 0);
    endtask

    task automatic t_clean_cmp_reg();
        int hs, fa; bit ok;
        glitch = 1'b1;
        run_bist(1'b0, 1'b1, 0, hs, ok, fa);
        glitch = 1'b0;
        chk("R6 reg path handshakes", hs, NCFG);
        chk("R6 pre-window ignored (compare)", int'(fail), 0);
    endtask

    task automatic t_common_fault_cmp();
        int hs, fa; bit ok;
        inj_rows = '1; inj_cfgs = 8'b0000_0010;
        run_bist(1'b0, 1'b0, 0, hs, ok, fa);
        chk("R4 identical rows pass compare", int'(fail), 0);
    endtask

    task automatic t_common_fault_sum();
        int hs, fa; bit ok;
        inj_rows = '1; inj_cfgs = 8'b0000_0010;
        run_bist(1'b1, 1'b0, 0, hs, ok, fa);
        inj_rows = '0; inj_cfgs = '0;
        chk("R5 checksum catches common fault", int'(fail), 1);
        chk("R5 checksum fail_cfg", int'(fail_cfg), 1);
    endtask

    task automatic t_sticky();
        int hs, fa; bit ok;
        run_bist(1'b0, 1'b0, 0, hs, ok, fa);
        chk("R7 fail held across clean run", int'(fail), 1);
        chk("R7 fail_cfg held", int'(fail_cfg), 1);
        do_reset();
        chk("R7 fail cleared by reset", int'(fail), 0);
    endtask

    task automatic t_row_fault_cmp();
        int hs, fa; bit ok;
        inj_rows = 4'b0100; inj_cfgs = 8'b0000_1000;
        run_bist(1'b0, 1'b0, 0, hs, ok, fa);
        chk("R4 single row fault", int'(fail), 1);
        chk("R4 fail_cfg", int'(fail_cfg), 3);
        chk("R4 flagged during configuration", fa, 3);
        do_reset();
    endtask

    task automatic t_first_fault_sum_reg();
        int hs, fa; bit ok;
        inj_rows = 4'b0001; inj_cfgs = 8'b0001_0100;
        run_bist(1'b1, 1'b1, 0, hs, ok, fa);
        chk("R7 first failing configuration kept", int'(fail_cfg), 2);
        chk("R5 registered checksum fault", int'(fail), 1);
    endtask

    initial begin
        t_reset();
        t_clean_cmp_poke();
        t_clean_sum_reg();
        t_clean_cmp_reg();
        t_common_fault_cmp();
        t_common_fault_sum();
        t_sticky();
        t_row_fault_cmp();
        t_first_fault_sum_reg();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule